// File: doc/BRIEF.md
# ROM-Programmed Message Sequencer

This block runs a small byte-coded program held in an external read-only memory and turns it into a stream of characters for a UART transmitter. The program can contain timed pauses and text strings in any order, and it ends with a stop instruction. A single state machine fetches each instruction, decodes it, and either counts out a pause or streams the text bytes one at a time to the transmitter.

The memory port is a synchronous read. The block drives an address, and the memory returns the byte at that address one clock later. This means the memory is a registered block RAM whose output follows its address with a one-cycle lag. The transmitter side is a byte-wide valid/ready stream. The sequencer raises `tx_valid` with a byte on `tx_data`. It keeps both steady until the transmitter accepts the byte by raising `tx_ready` in the same cycle. A low `tx_ready` can stall the sequencer for any number of cycles. No byte is lost or repeated because of a stall.

The line must idle for at least one full character time after reset. Programs should therefore start with a pause of that length. With the default prescaler, one pause unit is 1250 cycles (10 µs at 125 MHz), so a count of 9 covers a character at 115200 baud.

Top module: `msg_seq_top`

## Requirements
- R1: After reset `tx_valid` and `halted` are low, `rom_addr` is 0, and execution starts at address 0.
- R2: Opcode bytes are pause = 0x81 (the next byte is the unit count), text = 0x82 (followed by the characters and a 0x00 terminator), and stop = 0x80. Any other opcode byte acts as stop.
- R3: For a program that starts with a pause of count N followed by text, the first `tx_valid` appears 8 + N·TICK_CYCLES cycles after reset release. A count of 0 ends the pause at once, so the first valid appears at cycle 7.
- R4: The text bytes are offered in program order. The 0x00 terminator is never offered.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R6: When `tx_ready` is held high, the bytes of one string are accepted every second cycle. `tx_valid` is low in the cycle after each acceptance.
- R7: From the acceptance of the last character of one string to the first character of the next string, separated by a pause of count N, the interval is 10 + N·TICK_CYCLES + 1 cycles.
- R8: Once `halted` rises, it stays high, `tx_valid` stays low, and `rom_addr` does not change until reset.
- R9: An unrecognised opcode at address 0 halts the sequencer without offering any byte, and `rom_addr` stays 0.
- R10: The program counter never wraps. Once the byte at the last address has been used, the sequencer halts with `rom_addr` at the last address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | PC_W | Program memory read address |
| rom_rdata | input | 8 | Program byte; it is the byte at the address presented one cycle earlier |
| tx_data | output | 8 | Character offered to the transmitter |
| tx_valid | output | 1 | `tx_data` holds a character to send |
| tx_ready | input | 1 | Transmitter accepts the character this cycle |
| halted | output | 1 | Sequencer has stopped |

## Verification
Every result has a fixed cycle position. A free-running counter in the bench counts clock edges from reset release, and all checks read values at the falling edge, where that counter equals the cycle index used in R3 and R7. The first-valid cycle follows from the eight-step path of fetch, decode, count-byte wait and load, plus N·TICK_CYCLES + 1 run cycles, plus fetch, decode, text-byte wait and send. Acceptance cycles are recorded only when valid and ready are both high at the falling edge. The spacing and gap checks (R6, R7) are exact differences between these recorded cycles. Stall stability (R5) is checked on the cycle that follows each refused offer.

// File: rtl/msg_seq_pkg.sv
package msg_seq_pkg;
  localparam logic [7:0] OP_HALT  = 8'h80;
  localparam logic [7:0] OP_DELAY = 8'h81;
  localparam logic [7:0] OP_MSG   = 8'h82;
  localparam logic [7:0] EOM_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_DLY_WAIT,
    ST_DLY_LOAD,
    ST_DLY_RUN,
    ST_MSG_FETCH,
    ST_MSG_SEND,
    ST_HALT
  } seq_state_t;
endpackage

// File: rtl/msg_seq_ticker.sv
module msg_seq_ticker #(
  parameter int TICK_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt <= '0;
    else if (cnt == LAST_CNT) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST_CNT);

  // Count never exceeds the prescaler limit.
  a_r3_tick_in_range: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt <= LAST_CNT));
endmodule

// File: rtl/msg_seq_delay.sv
module msg_seq_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             done
);
  logic [CNT_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) rem <= '0;
    else if (load) rem <= load_val;
    else if (tick && rem != '0) rem <= rem - 1'b1;
  end

  assign done = (rem == '0);

  // R3: without a load the remaining units only count down.
  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    !load |=> (rem <= $past(rem)));
endmodule

// File: rtl/msg_seq_ctrl.sv
module msg_seq_ctrl
  import msg_seq_pkg::*;
#(
  parameter int PC_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] rom_addr,
  input  logic [7:0]      rom_rdata,
  output logic [7:0]      tx_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic            halted,
  output logic            dly_load,
  output logic [7:0]      dly_val,
  output logic            dly_run,
  input  logic            dly_done
);
  localparam logic [PC_W-1:0] PC_LAST = '1;

  seq_state_t      st, st_n, adv_to;
  logic [PC_W-1:0] pc, pc_n;
  logic            adv;

  always_comb begin
    st_n     = st;
    pc_n     = pc;
    adv      = 1'b0;
    adv_to   = ST_FETCH;
    dly_load = 1'b0;
    case (st)
      ST_FETCH: st_n = ST_DECODE;
      ST_DECODE: begin
        if (rom_rdata == OP_DELAY) begin
          adv = 1'b1; adv_to = ST_DLY_WAIT;
        end else if (rom_rdata == OP_MSG) begin
          adv = 1'b1; adv_to = ST_MSG_FETCH;
        end else begin
          st_n = ST_HALT;
        end
      end
      ST_DLY_WAIT: st_n = ST_DLY_LOAD;
      ST_DLY_LOAD: begin
        dly_load = 1'b1;
        if (rom_rdata == 8'd0) begin
          adv = 1'b1; adv_to = ST_FETCH;
        end else begin
          st_n = ST_DLY_RUN;
        end
      end
      ST_DLY_RUN: begin
        if (dly_done) begin
          adv = 1'b1; adv_to = ST_FETCH;
        end
      end
      ST_MSG_FETCH: st_n = ST_MSG_SEND;
      ST_MSG_SEND: begin
        if (rom_rdata == EOM_BYTE) begin
          adv = 1'b1; adv_to = ST_FETCH;
        end else if (tx_ready) begin
          adv = 1'b1; adv_to = ST_MSG_FETCH;
        end
      end
      ST_HALT: st_n = ST_HALT;
      default: st_n = ST_HALT;
    endcase
    if (adv) begin
      if (pc == PC_LAST) begin
        st_n = ST_HALT;
      end else begin
        pc_n = pc + 1'b1;
        st_n = adv_to;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_FETCH;
      pc <= '0;
    end else begin
      st <= st_n;
      pc <= pc_n;
    end
  end

  assign rom_addr = pc;
  assign tx_data  = rom_rdata;
  assign tx_valid = (st == ST_MSG_SEND) && (rom_rdata != EOM_BYTE);
  assign halted   = (st == ST_HALT);
  assign dly_val  = rom_rdata;
  assign dly_run  = (st == ST_DLY_RUN);

  a_r5_hold_offer: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  a_r6_gap_after_accept: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_valid);
  a_r4_no_terminator: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_data != EOM_BYTE));
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !tx_valid && $stable(rom_addr)));
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rom_addr >= $past(rom_addr)));
endmodule

// File: rtl/msg_seq_top.sv
module msg_seq_top #(
  parameter int PC_W        = 9,
  parameter int TICK_CYCLES = 1250
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] rom_addr,
  input  logic [7:0]      rom_rdata,
  output logic [7:0]      tx_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic            halted
);
  logic       dly_load, dly_run, dly_done, tick;
  logic [7:0] dly_val;

  msg_seq_ctrl #(.PC_W(PC_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .halted(halted),
    .dly_load(dly_load), .dly_val(dly_val), .dly_run(dly_run),
    .dly_done(dly_done)
  );

  msg_seq_ticker #(.TICK_CYCLES(TICK_CYCLES)) ticker_i (
    .clk(clk), .rst(rst), .clear(dly_load), .run(dly_run), .tick(tick)
  );

  msg_seq_delay #(.CNT_W(8)) delay_i (
    .clk(clk), .rst(rst), .load(dly_load), .load_val(dly_val),
    .tick(tick), .done(dly_done)
  );

  // R1: reset leaves the block idle at address zero.
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (rst || (!tx_valid && !halted && rom_addr == '0)));
endmodule

// File: tb/msg_seq_top_tb_top.sv
module msg_seq_top_tb_top;
  localparam int PW = 5;
  localparam int TK = 4;
  localparam int DEPTH = 1 << PW;
  localparam logic [7:0] P_HALT = 8'h80, P_DLY = 8'h81, P_MSG = 8'h82, P_EOM = 8'h00;
  localparam int NV = 5;
  localparam int TBL_N   [NV] = '{0, 1, 3, 7, 20};
  localparam int TBL_EXP [NV] = '{7, 12, 20, 36, 88};

  logic clk = 0, rst = 1, tx_ready = 1;
  logic [PW-1:0] rom_addr;
  logic [7:0] rom_q, tx_data;
  logic tx_valid, halted;
  logic [7:0] rom_mem [DEPTH];

  int checks = 0, fails = 0, cyc = 0;
  int nbytes, first_cyc, stall_err, stalls, ready_mode;
  logic [7:0] got [64];
  int hs_cyc [64];
  logic prev_stall;
  logic [7:0] prev_data;

  always #4 clk = ~clk;

  always_ff @(posedge clk) rom_q <= rom_mem[rom_addr];
  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  msg_seq_top #(.PC_W(PW), .TICK_CYCLES(TK)) dut_i (
    .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_rdata(rom_q),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .halted(halted)
  );

  always @(negedge clk) begin
    if (rst) begin
      prev_stall = 0;
      tx_ready = 1;
    end else begin
      tx_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 1);
      if (prev_stall && !(tx_valid && tx_data == prev_data)) stall_err++;
      if (tx_valid && first_cyc < 0) first_cyc = cyc;
      if (tx_valid && tx_ready && nbytes < 64) begin
        got[nbytes] = tx_data; hs_cyc[nbytes] = cyc; nbytes++;
      end
      if (tx_valid && !tx_ready) stalls++;
      prev_stall = tx_valid && !tx_ready;
      prev_data = tx_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < DEPTH; i++) rom_mem[i] = P_HALT;
  endtask

  task automatic start(input int mode);
    rst = 1;
    ready_mode = mode;
    nbytes = 0; first_cyc = -1; stall_err = 0; stalls = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_halt(input int maxc);
    for (int i = 0; i < maxc && !halted; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_rom();
    ready_mode = 0;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(!tx_valid && !halted && rom_addr == 0, "R1 reset idle", {tx_valid, halted}, 0);

    // R3/R4 vector table: pause of N units then one character
    for (int v = 0; v < NV; v++) begin
      clear_rom();
      rom_mem[0] = P_DLY; rom_mem[1] = 8'(TBL_N[v]);
      rom_mem[2] = P_MSG; rom_mem[3] = "Z"; rom_mem[4] = P_EOM;
      start(0);
      wait_halt(500);
      check(first_cyc == TBL_EXP[v], "R3 first valid cycle", first_cyc, TBL_EXP[v]);
      check(nbytes == 1 && got[0] == "Z", "R4 single char", nbytes, 1);
      check(halted, "R2 stop opcode halts", halted, 1);
    end

    // R4/R6: string with ready high
    clear_rom();
    rom_mem[0] = P_DLY; rom_mem[1] = 0; rom_mem[2] = P_MSG;
    rom_mem[3] = "H"; rom_mem[4] = "i"; rom_mem[5] = "!"; rom_mem[6] = P_EOM;
    start(0);
    wait_halt(500);
    check(nbytes == 3 && got[0] == "H" && got[1] == "i" && got[2] == "!",
          "R4 byte order", nbytes, 3);
    check(hs_cyc[1] - hs_cyc[0] == 2 && hs_cyc[2] - hs_cyc[1] == 2,
          "R6 spacing", hs_cyc[1] - hs_cyc[0], 2);

    // R5: same string under back-pressure
    start(1);
    wait_halt(500);
    check(nbytes == 3 && got[0] == "H" && got[1] == "i" && got[2] == "!",
          "R5 order under stall", nbytes, 3);
    check(stalls > 0, "R5 stall occurred", stalls, 1);
    check(stall_err == 0, "R5 hold while stalled", stall_err, 0);

    // R7: two strings separated by a pause
    clear_rom();
    rom_mem[0] = P_DLY; rom_mem[1] = 2; rom_mem[2] = P_MSG; rom_mem[3] = "A";
    rom_mem[4] = P_EOM; rom_mem[5] = P_DLY; rom_mem[6] = 3; rom_mem[7] = P_MSG;
    rom_mem[8] = "B"; rom_mem[9] = P_EOM;
    start(0);
    wait_halt(500);
    check(first_cyc == 8 + 2 * TK, "R3 mixed first", first_cyc, 8 + 2 * TK);
    check(nbytes == 2 && got[0] == "A" && got[1] == "B", "R4 mixed bytes", nbytes, 2);
    check(hs_cyc[1] - hs_cyc[0] == 10 + 3 * TK + 1, "R7 inter-string gap",
          hs_cyc[1] - hs_cyc[0], 10 + 3 * TK + 1);

    // R8: halt persists
    begin
      logic [PW-1:0] a0;
      int bad;
      a0 = rom_addr; bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!halted || tx_valid || rom_addr != a0) bad++;
      end
      check(bad == 0, "R8 halt sticky", bad, 0);
    end

    // R9: unrecognised opcode
    clear_rom();
    rom_mem[0] = 8'h55; rom_mem[1] = P_MSG; rom_mem[2] = "x"; rom_mem[3] = P_EOM;
    start(0);
    repeat (20) @(negedge clk);
    check(halted && nbytes == 0, "R9 unknown opcode halts", nbytes, 0);
    check(rom_addr == 0, "R9 address held", rom_addr, 0);

    // R10: string runs to the last address without terminator
    clear_rom();
    rom_mem[0] = P_DLY; rom_mem[1] = 0; rom_mem[2] = P_MSG;
    for (int i = 3; i < DEPTH; i++) rom_mem[i] = 8'(8'h41 + i - 3);
    start(0);
    wait_halt(500);
    check(nbytes == DEPTH - 3, "R10 bytes to end", nbytes, DEPTH - 3);
    check(got[DEPTH - 4] == 8'(8'h41 + DEPTH - 4), "R10 last byte",
          got[DEPTH - 4], 8'h41 + DEPTH - 4);
    check(halted && rom_addr == PW'(DEPTH - 1), "R10 no wrap", rom_addr, DEPTH - 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule